// File: doc/BRIEF.md
# Privileged control register bank

This block holds the 64-bit privileged control and status registers of a processor core. Software reaches them through a 6-bit register index. There is one write port, which commits at the clock edge, and one read port, whose data follows the read index within the same cycle. Each register has its own write behaviour. Some keep only a masked subset of the written bits. Some are cleared by any write. Some cannot be written, some cannot be read, and one is set to a constant by a write.

Writes to six of the registers also send a one-cycle command to an external address-translation buffer, one set for the data side and one for the instruction side. The commands are: drop all entries, drop the per-process entries, or drop one address. The single-address command also carries the written address and the address-space number taken from that side's ASN register. The cycle-count register returns its stored upper half together with a free-running 32-bit counter in the lower half. Any access that the target register does not allow gives a one-cycle fault pulse.

Top module: `priv_ctl_bank`

## Requirements
- R1: Reset (active-low, synchronous) clears every register, the cycle counter, `fault`, all invalidate pulses, `inv_addr` and `inv_asn` to zero.
- R2: A write keeps only the bits in the register's mask. Scratch 0x00–0x03 keep all bits. Exception address 0x04 keeps all bits except bit 1. Trap request 0x05 and trap enable 0x06 keep 0xF. Priority level 0x07 keeps 0x1F. Mode registers 0x08 and 0x09 keep 0x18. Soft-interrupt request 0x0A keeps 0x7FFF0. Instruction ASN 0x0B keeps 0x7F0. Data ASN 0x0C keeps bits 63:57.
- R3: Any write to exception summary 0x0D or exception mask 0x0E leaves the register at zero.
- R4: Read-only registers 0x10 and 0x11 read their stored value (zero) without a fault. A write to either changes nothing and raises `fault`.
- R5: Write-only registers return zero and raise `fault` when read. These are interrupt-clear 0x12, cache-flush 0x13, counter-control 0x15, and the invalidate registers 0x18–0x1A and 0x1C–0x1E. A write to counter-control stores 1.
- R6: Undefined indices (0x0F, 0x16, 0x17, 0x1B, 0x1F, 0x20–0x3F) read as zero and raise `fault` on both a read and a write.
- R7: Reading cycle-count 0x14 returns bits 63:32 of the stored value and, in bits 31:0, the number of rising clock edges since reset was released. A write stores all 64 bits.
- R8: A write to 0x18, 0x19, 0x1C or 0x1D stores zero. In the next cycle, and only that cycle, it drives `d_inv_all`, `d_inv_proc`, `i_inv_all` or `i_inv_proc` high, respectively.
- R9: A write to 0x1A (data side) or 0x1E (instruction side) pulses `d_inv_one` or `i_inv_one` for one cycle. In that same cycle `inv_addr` carries the written data. `inv_asn` carries bits 63:57 of register 0x0C for the data side, or bits 10:4 of register 0x0B for the instruction side.
- R10: `fault` is high in the cycle after a disallowed access and low otherwise. A read is an access only while `rd_en` is high. A bad read and a bad write in the same cycle give one pulse.
- R11: A read and a write of the same index in the same cycle return the old value. The new value is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read access strobe (used for fault detection) |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Read data, combinational from `rd_idx` |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| fault | output | 1 | One-cycle pulse after a disallowed access |
| d_inv_all | output | 1 | Data-side invalidate-all pulse |
| d_inv_proc | output | 1 | Data-side invalidate-process pulse |
| d_inv_one | output | 1 | Data-side invalidate-address pulse |
| i_inv_all | output | 1 | Instruction-side invalidate-all pulse |
| i_inv_proc | output | 1 | Instruction-side invalidate-process pulse |
| i_inv_one | output | 1 | Instruction-side invalidate-address pulse |
| inv_addr | output | 64 | Address carried with an invalidate-address pulse |
| inv_asn | output | 7 | Address-space number carried with an invalidate-address pulse |

## Verification
The read port and the write port work independently, so one cycle can contain both a read and a write. Two cases of this are tested. In the first, both ports target the same scratch register: the read data is sampled inside that cycle and again one cycle later, to show the old value first and the new value after the edge. In the second, an undefined-index read and a write to a read-only register are issued together. The bench then requires exactly one `fault` pulse, followed by a low `fault` in the next cycle.

// File: rtl/ctlbank_pkg.sv
// Package: index map, register kinds and write masks of the control bank.
// Assumes a 6-bit index. Only indices below SLOTS are ever backed by storage.
package ctlbank_pkg;

    localparam int IDX_W    = 6;
    localparam int DATA_W   = 64;
    localparam int ASN_W    = 7;
    localparam int CNT_W    = 32;
    localparam int SLOTS    = 32;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int IASN_LSB = 4;
    localparam int DASN_LSB = DATA_W - ASN_W;

    // Index map (invalidate triplets must stay consecutive: all, proc, one)
    localparam logic [IDX_W-1:0] IX_SCR0     = 6'h00;
    localparam logic [IDX_W-1:0] IX_SCR1     = 6'h01;
    localparam logic [IDX_W-1:0] IX_SCR2     = 6'h02;
    localparam logic [IDX_W-1:0] IX_SCR3     = 6'h03;
    localparam logic [IDX_W-1:0] IX_EXC_ADDR = 6'h04;
    localparam logic [IDX_W-1:0] IX_TRAP_REQ = 6'h05;
    localparam logic [IDX_W-1:0] IX_TRAP_EN  = 6'h06;
    localparam logic [IDX_W-1:0] IX_PRIO     = 6'h07;
    localparam logic [IDX_W-1:0] IX_MODE_I   = 6'h08;
    localparam logic [IDX_W-1:0] IX_MODE_D   = 6'h09;
    localparam logic [IDX_W-1:0] IX_SOFT_REQ = 6'h0A;
    localparam logic [IDX_W-1:0] IX_IASN     = 6'h0B;
    localparam logic [IDX_W-1:0] IX_DASN     = 6'h0C;
    localparam logic [IDX_W-1:0] IX_EXC_SUM  = 6'h0D;
    localparam logic [IDX_W-1:0] IX_EXC_MSK  = 6'h0E;
    localparam logic [IDX_W-1:0] IX_INT_ID   = 6'h10;
    localparam logic [IDX_W-1:0] IX_MM_STAT  = 6'h11;
    localparam logic [IDX_W-1:0] IX_HW_CLR   = 6'h12;
    localparam logic [IDX_W-1:0] IX_C_FLUSH  = 6'h13;
    localparam logic [IDX_W-1:0] IX_CYC      = 6'h14;
    localparam logic [IDX_W-1:0] IX_CYC_CTL  = 6'h15;
    localparam logic [IDX_W-1:0] IX_DINV_ALL = 6'h18;
    localparam logic [IDX_W-1:0] IX_DINV_PRC = 6'h19;
    localparam logic [IDX_W-1:0] IX_DINV_ONE = 6'h1A;
    localparam logic [IDX_W-1:0] IX_IINV_ALL = 6'h1C;
    localparam logic [IDX_W-1:0] IX_IINV_PRC = 6'h1D;
    localparam logic [IDX_W-1:0] IX_IINV_ONE = 6'h1E;

    typedef enum logic [3:0] {
        RK_UNDEF, RK_MASKED, RK_RDONLY, RK_WRONLY, RK_CLEAR,
        RK_CYCLE, RK_SETONE, RK_INVZERO, RK_INVDATA
    } rkind_e;

    typedef struct packed {
        rkind_e              kind;
        logic [DATA_W-1:0]   mask;
    } rattr_t;

    // Attributes of one index: kind and the bits a write may keep
    function automatic rattr_t attr_of(input logic [IDX_W-1:0] ix);
        rattr_t a;
        a.kind = RK_UNDEF;
        a.mask = '1;
        case (ix)
            IX_SCR0, IX_SCR1, IX_SCR2, IX_SCR3: a.kind = RK_MASKED;
            IX_EXC_ADDR: begin a.kind = RK_MASKED; a.mask = 64'hFFFF_FFFF_FFFF_FFFD; end
            IX_TRAP_REQ, IX_TRAP_EN: begin a.kind = RK_MASKED; a.mask = 64'hF; end
            IX_PRIO:     begin a.kind = RK_MASKED; a.mask = 64'h1F; end
            IX_MODE_I, IX_MODE_D: begin a.kind = RK_MASKED; a.mask = 64'h18; end
            IX_SOFT_REQ: begin a.kind = RK_MASKED; a.mask = 64'h7_FFF0; end
            IX_IASN:     begin a.kind = RK_MASKED; a.mask = 64'h7F0; end
            IX_DASN:     begin a.kind = RK_MASKED; a.mask = 64'hFE00_0000_0000_0000; end
            IX_EXC_SUM, IX_EXC_MSK: a.kind = RK_CLEAR;
            IX_INT_ID, IX_MM_STAT:  a.kind = RK_RDONLY;
            IX_HW_CLR, IX_C_FLUSH:  a.kind = RK_WRONLY;
            IX_CYC:      a.kind = RK_CYCLE;
            IX_CYC_CTL:  a.kind = RK_SETONE;
            IX_DINV_ALL, IX_DINV_PRC, IX_IINV_ALL, IX_IINV_PRC: a.kind = RK_INVZERO;
            IX_DINV_ONE, IX_IINV_ONE: a.kind = RK_INVDATA;
            default:     a.kind = RK_UNDEF;
        endcase
        return a;
    endfunction

    function automatic logic can_read(input rkind_e k);
        return (k == RK_MASKED) || (k == RK_RDONLY) || (k == RK_CLEAR) || (k == RK_CYCLE);
    endfunction

    function automatic logic can_write(input rkind_e k);
        return (k != RK_UNDEF) && (k != RK_RDONLY);
    endfunction

endpackage

// File: rtl/ctlbank_decode.sv
// Index decoder: turns a register index into its kind and write mask.
// Assumes nothing beyond the package map; purely combinational.
module ctlbank_decode
    import ctlbank_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output rattr_t           attr
);
    // Look up the attribute record for the presented index
    always_comb attr = attr_of(idx);
endmodule

// File: rtl/ctlbank_cycle.sv
// Free-running cycle counter, zeroed by reset, wraps at 2**W.
// Assumes synchronous active-low reset.
module ctlbank_cycle #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Count every rising edge outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + W'(1);
    end

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == W'($past(cnt) + W'(1)));
endmodule

// File: rtl/ctlbank_store.sv
// Register storage: one 64-bit slot per backed index, updated by the write port.
// Assumes wr_attr/wr_ok are the decode of wr_idx; undefined and read-only slots
// are never written and stay at their reset value.
module ctlbank_store
    import ctlbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  rattr_t                        wr_attr,
    input  logic                          wr_ok,
    output logic [SLOTS-1:0][DATA_W-1:0]  regs
);
    logic [DATA_W-1:0] wr_val;

    // Value a permitted write leaves in its slot
    always_comb begin
        case (wr_attr.kind)
            RK_CLEAR, RK_INVZERO: wr_val = '0;
            RK_SETONE:            wr_val = DATA_W'(1);
            default:              wr_val = wr_data & wr_attr.mask;
        endcase
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] q;
        // Capture the write aimed at this slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_ok && (wr_idx == IDX_W'(s)))
                q <= wr_val;
        end
        assign regs[s] = q;
    end

    a_r3_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_EXC_SUM |=> regs[SLOT_W'(IX_EXC_SUM)] == '0);
    a_r2_prio_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_PRIO |=> regs[SLOT_W'(IX_PRIO)][DATA_W-1:5] == '0);
    a_r2_excaddr_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        regs[SLOT_W'(IX_EXC_ADDR)][1] == 1'b0);
    a_r4_rdonly_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_INT_ID |=> $stable(regs[SLOT_W'(IX_INT_ID)]));
endmodule

// File: rtl/priv_ctl_bank.sv
// Privileged control register bank top: decodes both ports, reads combinationally,
// registers the fault flag and the translation-buffer invalidate commands.
// Assumes one write per cycle; invalidate indices on each side are consecutive.
module priv_ctl_bank
    import ctlbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [5:0]         rd_idx,
    output logic [63:0]        rd_data,
    input  logic               wr_en,
    input  logic [5:0]         wr_idx,
    input  logic [63:0]        wr_data,
    output logic               fault,
    output logic               d_inv_all,
    output logic               d_inv_proc,
    output logic               d_inv_one,
    output logic               i_inv_all,
    output logic               i_inv_proc,
    output logic               i_inv_one,
    output logic [63:0]        inv_addr,
    output logic [6:0]         inv_asn
);
    rattr_t                       rd_attr, wr_attr;
    logic                         rd_ok, wr_ok;
    logic [SLOTS-1:0][DATA_W-1:0] regs;
    logic [CNT_W-1:0]             cyc_cnt;
    logic [SLOT_W-1:0]            rd_slot;
    logic [1:0]                   hit_all, hit_proc, hit_one;
    logic [1:0][ASN_W-1:0]        side_asn;

    ctlbank_decode u_rd_dec (.idx(rd_idx), .attr(rd_attr));
    ctlbank_decode u_wr_dec (.idx(wr_idx), .attr(wr_attr));

    assign rd_ok   = can_read(rd_attr.kind);
    assign wr_ok   = can_write(wr_attr.kind);
    assign rd_slot = rd_idx[SLOT_W-1:0];

    ctlbank_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_attr(wr_attr), .wr_ok(wr_ok), .regs(regs)
    );

    ctlbank_cycle #(.W(CNT_W)) u_cycle (.clk(clk), .rst_n(rst_n), .cnt(cyc_cnt));

    // Read mux: readable slots only, cycle register merges the live count
    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            if (rd_attr.kind == RK_CYCLE)
                rd_data = {regs[rd_slot][DATA_W-1:CNT_W], cyc_cnt};
            else
                rd_data = regs[rd_slot];
        end
    end

    assign side_asn[0] = regs[SLOT_W'(IX_DASN)][DASN_LSB +: ASN_W];
    assign side_asn[1] = regs[SLOT_W'(IX_IASN)][IASN_LSB +: ASN_W];

    for (genvar sd = 0; sd < 2; sd++) begin : g_side
        localparam logic [IDX_W-1:0] BASE = (sd == 0) ? IX_DINV_ALL : IX_IINV_ALL;
        assign hit_all[sd]  = wr_en && (wr_idx == BASE);
        assign hit_proc[sd] = wr_en && (wr_idx == IDX_W'(BASE + 1));
        assign hit_one[sd]  = wr_en && (wr_idx == IDX_W'(BASE + 2));
    end

    // Registered fault flag and invalidate commands, one cycle each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault      <= 1'b0;
            d_inv_all  <= 1'b0;
            d_inv_proc <= 1'b0;
            d_inv_one  <= 1'b0;
            i_inv_all  <= 1'b0;
            i_inv_proc <= 1'b0;
            i_inv_one  <= 1'b0;
            inv_addr   <= '0;
            inv_asn    <= '0;
        end else begin
            fault      <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
            d_inv_all  <= hit_all[0];
            d_inv_proc <= hit_proc[0];
            d_inv_one  <= hit_one[0];
            i_inv_all  <= hit_all[1];
            i_inv_proc <= hit_proc[1];
            i_inv_one  <= hit_one[1];
            if (hit_one[0]) begin
                inv_addr <= wr_data;
                inv_asn  <= side_asn[0];
            end else if (hit_one[1]) begin
                inv_addr <= wr_data;
                inv_asn  <= side_asn[1];
            end else begin
                inv_addr <= '0;
                inv_asn  <= '0;
            end
        end
    end

    a_r8_dinv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_DINV_ALL |=> d_inv_all);
    a_r8_dinv_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IX_DINV_ALL) |=> !d_inv_all);
    a_r6_undef_write_fault: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx >= IDX_W'(SLOTS) |=> fault);
    a_r9_dasn_carried: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IX_DINV_ONE |=>
            d_inv_one && inv_asn == $past(regs[SLOT_W'(IX_DASN)][DASN_LSB +: ASN_W]));
    a_r10_quiet_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !wr_en |=> !fault);
endmodule

// File: tb/sim_priv_ctl_bank.sv
`timescale 1ns/1ps
module sim_priv_ctl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        fault, d_inv_all, d_inv_proc, d_inv_one, i_inv_all, i_inv_proc, i_inv_one;
    logic [63:0] inv_addr;
    logic [6:0]  inv_asn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] bcnt;

    always #4 clk = ~clk;

    priv_ctl_bank u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .fault(fault),
        .d_inv_all(d_inv_all), .d_inv_proc(d_inv_proc), .d_inv_one(d_inv_one),
        .i_inv_all(i_inv_all), .i_inv_proc(i_inv_proc), .i_inv_one(i_inv_one),
        .inv_addr(inv_addr), .inv_asn(inv_asn)
    );

    // Expected cycle count: edges since reset release
    always @(posedge clk) begin
        if (!rst_n) bcnt <= '0;
        else        bcnt <= bcnt + 32'd1;
    end

    typedef struct packed {
        logic [23:0] tag;
        logic [5:0]  ix;
        logic [63:0] data;
        logic [63:0] exp_rd;
        logic        exp_flt;
    } vec_t;

    localparam int NV = 11;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VECS [NV] = '{
        '{"R2 ", 6'h00, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 1'b0},
        '{"R2 ", 6'h04, ONES, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0},
        '{"R2 ", 6'h05, ONES, 64'hF, 1'b0},
        '{"R2 ", 6'h07, ONES, 64'h1F, 1'b0},
        '{"R2 ", 6'h09, ONES, 64'h18, 1'b0},
        '{"R2 ", 6'h0A, ONES, 64'h7_FFF0, 1'b0},
        '{"R2 ", 6'h0B, ONES, 64'h7F0, 1'b0},
        '{"R2 ", 6'h0C, ONES, 64'hFE00_0000_0000_0000, 1'b0},
        '{"R3 ", 6'h0D, ONES, 64'h0, 1'b0},
        '{"R3 ", 6'h0E, 64'h1234, 64'h0, 1'b0},
        '{"R4 ", 6'h10, ONES, 64'h0, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] ix, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = ix; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobed read: returns data in the read cycle, leaves caller one cycle later
    task automatic rdf(input logic [5:0] ix, output logic [63:0] d, output logic [31:0] c);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = ix;
        #1; d = rd_data; c = bcnt;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [31:0] c;
        logic [63:0] d2;
        logic [31:0] c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1 scratch", rd_data, 64'h0);
        chk("R1 fault/pulses", {57'h0, fault, d_inv_all, d_inv_proc, d_inv_one,
            i_inv_all, i_inv_proc, i_inv_one}, 64'h0);
        chk("R1 inv_addr", inv_addr, 64'h0);

        // R2 R3 R4 table walk
        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].ix, VECS[k].data);
            chk($sformatf("%s fault row %0d", VECS[k].tag, k), {63'h0, fault}, {63'h0, VECS[k].exp_flt});
            rd_idx = VECS[k].ix;
            #1;
            chk($sformatf("%s readback row %0d", VECS[k].tag, k), rd_data, VECS[k].exp_rd);
        end

        // R4: read of read-only register, no fault
        rdf(6'h11, d, c);
        chk("R4 ro read data", d, 64'h0);
        chk("R4 ro read no fault", {63'h0, fault}, 64'h0);

        // R5: write-only registers read zero and fault
        wr(6'h12, 64'h5A5A);
        rdf(6'h12, d, c);
        chk("R5 wo read data", d, 64'h0);
        chk("R5 wo read fault", {63'h0, fault}, 64'h1);
        wr(6'h15, 64'h0);
        chk("R5 ctl write no fault", {63'h0, fault}, 64'h0);
        rdf(6'h15, d, c);
        chk("R5 ctl read data", d, 64'h0);
        chk("R5 ctl read fault", {63'h0, fault}, 64'h1);

        // R6: undefined indices
        rdf(6'h2A, d, c);
        chk("R6 undef read data", d, 64'h0);
        chk("R6 undef read fault", {63'h0, fault}, 64'h1);
        wr(6'h0F, ONES);
        chk("R6 undef write fault", {63'h0, fault}, 64'h1);
        rd_idx = 6'h0F; #1;
        chk("R6 undef after write", rd_data, 64'h0);

        // R7: cycle count merge
        wr(6'h14, 64'hABCD_1234_5555_5555);
        rdf(6'h14, d, c);
        chk("R7 upper", {32'h0, d[63:32]}, 64'hABCD_1234);
        chk("R7 lower", {32'h0, d[31:0]}, {32'h0, c});
        chk("R7 read no fault", {63'h0, fault}, 64'h0);
        repeat (3) @(negedge clk);
        rdf(6'h14, d2, c2);
        chk("R7 lower later", {32'h0, d2[31:0]}, {32'h0, c2});

        // R8: invalidate all / process pulses
        wr(6'h18, 64'h55);
        chk("R8 d_inv_all pulse", {58'h0, d_inv_all, d_inv_proc, d_inv_one,
            i_inv_all, i_inv_proc, i_inv_one}, 64'b100000);
        @(negedge clk);
        chk("R8 d_inv_all one cycle", {63'h0, d_inv_all}, 64'h0);
        wr(6'h1D, 64'h77);
        chk("R8 i_inv_proc pulse", {58'h0, d_inv_all, d_inv_proc, d_inv_one,
            i_inv_all, i_inv_proc, i_inv_one}, 64'b000010);
        @(negedge clk);
        chk("R8 i_inv_proc one cycle", {63'h0, i_inv_proc}, 64'h0);

        // R9: invalidate one address with ASN
        wr(6'h0C, 64'h5400_0000_0000_0000);
        wr(6'h1A, 64'h1234_5678_9ABC_DEF0);
        chk("R9 d_inv_one", {63'h0, d_inv_one}, 64'h1);
        chk("R9 d addr", inv_addr, 64'h1234_5678_9ABC_DEF0);
        chk("R9 d asn", {57'h0, inv_asn}, 64'h2A);
        wr(6'h0B, 64'h350);
        wr(6'h1E, 64'h0000_0000_0BAD_F00D);
        chk("R9 i_inv_one", {62'h0, d_inv_one, i_inv_one}, 64'b01);
        chk("R9 i addr", inv_addr, 64'h0BAD_F00D);
        chk("R9 i asn", {57'h0, inv_asn}, 64'h35);
        @(negedge clk);
        chk("R9 i_inv_one one cycle", {63'h0, i_inv_one}, 64'h0);

        // R10: bad index without rd_en, then two bad accesses together
        @(negedge clk);
        rd_en = 1'b0; rd_idx = 6'h3F;
        @(negedge clk);
        chk("R10 no strobe no fault", {63'h0, fault}, 64'h0);
        rd_en = 1'b1; rd_idx = 6'h2A; wr_en = 1'b1; wr_idx = 6'h10; wr_data = ONES;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R10 combined fault", {63'h0, fault}, 64'h1);
        @(negedge clk);
        chk("R10 fault drops", {63'h0, fault}, 64'h0);

        // R11: same-cycle read and write
        wr(6'h01, 64'hAAAA);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'h01; wr_data = 64'hBBBB; rd_idx = 6'h01;
        #1;
        chk("R11 old value", rd_data, 64'hAAAA);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R11 new value", rd_data, 64'hBBBB);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_idx = 6'h00; #1;
        chk("R1 scratch after reset", rd_data, 64'h0);
        rd_idx = 6'h0C; #1;
        chk("R1 asn after reset", rd_data, 64'h0);
        rd_idx = 6'h14; #1;
        chk("R1 counter after reset", rd_data, {32'h0, bcnt});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule